// File: doc/BRIEF.md
# Reconfiguration Cause History Logger

This block keeps a small debug trail of why a configurable device abandoned its running application image. Five trigger lines report the possible reasons. When the combined trigger condition rises while the device runs an application image, the block reduces the active triggers to one cause bit. It then builds a 31-bit record holding that cause, the master-state code and the boot address of the image being left. The record is pushed into a two-entry history.

A registered read port returns one of three words, chosen by a select input. The first is the current-state word. Its layout depends on whether the device is in factory mode or in application mode, and in application mode a view input picks between a watchdog layout and a boot-address layout. The other two words are the two history entries. A history read issued before the device has ever entered application mode returns an all-ones marker that no legal record can equal.

Top module: `cfg_exit_logger`

## Requirements
- R1: While `rst_n` is low, the next clock edge clears `rd_data` to zero, `rd_valid` to zero, both history entries to zero and the application-entered flag.
- R2: `trig_i[4]`, `trig_i[3]`, `trig_i[2]`, `trig_i[1]` and `trig_i[0]` map to record bits 30, 29, 28, 27 and 26. A record has exactly one of these bits set: the one for the highest-indexed trigger asserted in the logging cycle.
- R3: In a history record, bit 31 is zero, bits 25:24 hold `mstate` and bits 23:0 hold `boot_addr`, both as sampled in the logging cycle.
- R4: Each logged event loads the new record into history entry 1 and moves the old entry 1 into entry 2.
- R5: An event is logged only in a cycle where some trigger is high and no trigger was high in the previous cycle. A held trigger, or a second trigger raised while another is still held, logs nothing further.
- R6: While `app_mode` is 0, triggers leave both history entries unchanged.
- R7: With `app_mode` at 0, the current-state word is `{mstate, 6'b0, boot_addr}` for either value of `cur_view`.
- R8: With `app_mode` at 1 and `cur_view` at 1, the current-state word is `{mstate, wd_en, wd_timeout}`.
- R9: With `app_mode` at 1 and `cur_view` at 0, the current-state word is `{mstate, 6'b0, boot_addr}`.
- R10: The application-entered flag is set by any clock edge at which `app_mode` is 1 and `rst_n` is high. A read of entry 1 or entry 2 strobed while the flag is clear returns 32'hFFFFFFFF.
- R11: A strobe with `rd_sel` = 0 returns the current-state word, 1 returns entry 1, 2 returns entry 2 and 3 returns zero. `rd_data` and `rd_valid` change at the clock edge that samples the strobe. `rd_data` holds its value until the next strobe, and `rd_valid` is high for one cycle per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 5 | Trigger lines; bit 4 has the highest precedence |
| app_mode | input | 1 | 1 = application image running, 0 = factory image |
| mstate | input | 2 | Current master-state code |
| boot_addr | input | 24 | Boot address of the running image |
| wd_en | input | 1 | Watchdog enable setting |
| wd_timeout | input | 29 | Watchdog time-out setting |
| cur_view | input | 1 | Application-mode layout of the current word: 1 = watchdog, 0 = boot address |
| rd_sel | input | 2 | Read select: 0 current, 1 entry 1, 2 entry 2, 3 none |
| rd_strobe | input | 1 | Capture strobe for the read port |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle after each strobe |

## Verification
The hardest case to reach is a trigger that must not be logged. This happens either because a different line is already held high, or because the device is still in factory mode. In both cases nothing shows at the output until a later history read proves the entries did not move. The stimulus holds one trigger for several cycles and adds a higher-precedence trigger in the middle. It also fires triggers before the first entry into application mode. After each of these it reads both entries and expects the records left by the earlier events. Simultaneous multi-line triggers are applied with varied boot addresses and state codes, so that the cause priority and the field placement are checked separately.

// File: rtl/cfg_log_pkg.sv
package cfg_log_pkg;

  localparam int NTRIG  = 5;
  localparam int ST_W   = 2;
  localparam int ADDR_W = 24;
  localparam int WDT_W  = 29;
  localparam int WORD_W = 32;
  localparam int PAD_W  = WORD_W - ST_W - ADDR_W;
  localparam int REC_PAD_W = WORD_W - NTRIG - ST_W - ADDR_W;

  localparam logic [WORD_W-1:0] BAD_CAPTURE = {WORD_W{1'b1}};

  typedef enum logic [1:0] {
    SEL_CUR  = 2'd0,
    SEL_H1   = 2'd1,
    SEL_H2   = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  // Keep only the highest-indexed asserted trigger.
  function automatic logic [NTRIG-1:0] pick_cause(input logic [NTRIG-1:0] t);
    logic [NTRIG-1:0] c;
    c = '0;
    for (int i = 0; i < NTRIG; i++) begin
      if (t[i]) c = NTRIG'(1) << i;
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] make_record(
    input logic [NTRIG-1:0]  cause,
    input logic [ST_W-1:0]   st,
    input logic [ADDR_W-1:0] addr
  );
    return {{REC_PAD_W{1'b0}}, cause, st, addr};
  endfunction

  function automatic logic [WORD_W-1:0] cur_word(
    input logic              app,
    input logic              wd_view,
    input logic [ST_W-1:0]   st,
    input logic [ADDR_W-1:0] addr,
    input logic              wen,
    input logic [WDT_W-1:0]  wto
  );
    if (app && wd_view) return {st, wen, wto};
    return {st, {PAD_W{1'b0}}, addr};
  endfunction

endpackage

// File: rtl/trig_resolver.sv
module trig_resolver
  import cfg_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig,
  input  logic             app_mode,
  output logic             trig_any,
  output logic             log_evt,
  output logic [NTRIG-1:0] cause
);

  logic trig_any_q;
  logic trig_rise;

  assign trig_any  = |trig;
  assign trig_rise = trig_any & ~trig_any_q;
  assign log_evt   = trig_rise & app_mode;
  assign cause     = pick_cause(trig);

  always_ff @(posedge clk) begin
    if (!rst_n) trig_any_q <= 1'b0;
    else        trig_any_q <= trig_any;
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |-> $onehot(cause)); // R2

  AST_CAUSE_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |-> ((cause & trig) == cause)); // R2

  AST_CAUSE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |-> (cause > (trig ^ cause))); // R2

endmodule

// File: rtl/history_stack.sv
module history_stack
  import cfg_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_mode,
  input  logic              log_evt,
  input  logic [WORD_W-1:0] record,
  output logic [WORD_W-1:0] hist1,
  output logic [WORD_W-1:0] hist2,
  output logic              app_seen
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist1 <= '0;
      hist2 <= '0;
    end else if (log_evt) begin
      hist1 <= record;
      hist2 <= hist1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        app_seen <= 1'b0;
    else if (app_mode) app_seen <= 1'b1;
  end

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |=> hist2 == $past(hist1)); // R4

  AST_LOAD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |=> hist1 == $past(record)); // R3

  AST_FACTORY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !app_mode |=> $stable(hist1) && $stable(hist2)); // R6

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    app_seen |=> app_seen); // R10

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |=> !hist1[WORD_W-1]); // R3

endmodule

// File: rtl/read_port.sv
module read_port
  import cfg_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [1:0]        rd_sel,
  input  logic              app_mode,
  input  logic              cur_view,
  input  logic [ST_W-1:0]   mstate,
  input  logic [ADDR_W-1:0] boot_addr,
  input  logic              wd_en,
  input  logic [WDT_W-1:0]  wd_timeout,
  input  logic [WORD_W-1:0] hist1,
  input  logic [WORD_W-1:0] hist2,
  input  logic              app_seen,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [WORD_W-1:0] word_cur;
  logic [WORD_W-1:0] word_sel;
  logic              early_hist;
  rd_sel_e           sel;

  assign sel        = rd_sel_e'(rd_sel);
  assign word_cur   = cur_word(app_mode, cur_view, mstate, boot_addr, wd_en, wd_timeout);
  assign early_hist = ((sel == SEL_H1) || (sel == SEL_H2)) && !app_seen;

  always_comb begin
    unique case (sel)
      SEL_CUR:  word_sel = word_cur;
      SEL_H1:   word_sel = app_seen ? hist1 : BAD_CAPTURE;
      SEL_H2:   word_sel = app_seen ? hist2 : BAD_CAPTURE;
      default:  word_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= word_sel;
    end
  end

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid); // R11

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data) && !rd_valid); // R11

  AST_EARLY_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && early_hist) |=> rd_data == BAD_CAPTURE); // R10

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && sel == SEL_NONE) |=> rd_data == '0); // R11

endmodule

// File: rtl/cfg_exit_logger.sv
module cfg_exit_logger
  import cfg_log_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  trig_i,
  input  logic        app_mode,
  input  logic [1:0]  mstate,
  input  logic [23:0] boot_addr,
  input  logic        wd_en,
  input  logic [28:0] wd_timeout,
  input  logic        cur_view,
  input  logic [1:0]  rd_sel,
  input  logic        rd_strobe,
  output logic [31:0] rd_data,
  output logic        rd_valid
);

  logic              trig_any;
  logic              log_evt;
  logic [NTRIG-1:0]  cause;
  logic [WORD_W-1:0] record;
  logic [WORD_W-1:0] hist1;
  logic [WORD_W-1:0] hist2;
  logic              app_seen;

  assign record = make_record(cause, mstate, boot_addr);

  trig_resolver u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig_i),
    .app_mode (app_mode),
    .trig_any (trig_any),
    .log_evt  (log_evt),
    .cause    (cause)
  );

  history_stack u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .app_mode (app_mode),
    .log_evt  (log_evt),
    .record   (record),
    .hist1    (hist1),
    .hist2    (hist2),
    .app_seen (app_seen)
  );

  read_port u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .rd_sel     (rd_sel),
    .app_mode   (app_mode),
    .cur_view   (cur_view),
    .mstate     (mstate),
    .boot_addr  (boot_addr),
    .wd_en      (wd_en),
    .wd_timeout (wd_timeout),
    .hist1      (hist1),
    .hist2      (hist2),
    .app_seen   (app_seen),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  AST_LOG_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    log_evt |-> trig_any && app_mode); // R5

endmodule

// File: tb/sim_cfg_exit_logger.sv
module sim_cfg_exit_logger;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  trig_i = '0;
  logic        app_mode = 1'b0;
  logic [1:0]  mstate = '0;
  logic [23:0] boot_addr = '0;
  logic        wd_en = 1'b0;
  logic [28:0] wd_timeout = '0;
  logic        cur_view = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;

  always #2 clk = ~clk;

  cfg_exit_logger u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .app_mode(app_mode),
    .mstate(mstate), .boot_addr(boot_addr), .wd_en(wd_en),
    .wd_timeout(wd_timeout), .cur_view(cur_view), .rd_sel(rd_sel),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // independent reference state
  logic [31:0] m_h1 = '0, m_h2 = '0;
  logic        m_seen = 1'b0;
  logic        m_prev = 1'b0;

  function automatic logic [31:0] ref_record(input logic [4:0] t, input logic [1:0] s,
                                             input logic [23:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 4; b >= 0; b--) begin
      if (t[b]) begin
        r[26 + b] = 1'b1;
        break;
      end
    end
    r[25:24] = s;
    r[23:0]  = a;
    return r;
  endfunction

  function automatic logic [31:0] ref_current();
    logic [31:0] w;
    w = '0;
    w[31:30] = mstate;
    if (app_mode && cur_view) begin
      w[29]   = wd_en;
      w[28:0] = wd_timeout;
    end else begin
      w[23:0] = boot_addr;
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock; model follows the inputs applied during it
  task automatic tick(input string req);
    if (rd_strobe) begin
      case (rd_sel)
        2'd0: exp_q.push_back(ref_current());
        2'd1: exp_q.push_back(m_seen ? m_h1 : 32'hFFFF_FFFF);
        2'd2: exp_q.push_back(m_seen ? m_h2 : 32'hFFFF_FFFF);
        default: exp_q.push_back(32'h0);
      endcase
      tag_q.push_back(req);
    end
    if (app_mode && (trig_i != 0) && !m_prev) begin
      m_h2 = m_h1;
      m_h1 = ref_record(trig_i, mstate, boot_addr);
    end
    m_prev = (trig_i != 0);
    if (app_mode) m_seen = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic read(input logic [1:0] sel, input string req);
    rd_sel    = sel;
    rd_strobe = 1'b1;
    tick(req);
  endtask

  task automatic fire(input logic [4:0] t, input logic [23:0] a, input logic [1:0] s);
    boot_addr = a;
    mstate    = s;
    trig_i    = t;
    tick("R2");
    trig_i = '0;
    tick("R5");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R11 actual=unexpected valid expected=no data");
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R1: reset state
    rd_strobe = 1'b1;
    trig_i = 5'b00001;
    repeat (3) @(negedge clk);
    rd_strobe = 1'b0;
    trig_i = '0;
    check("R1", {31'b0, rd_valid}, 32'h0);
    check("R1", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // factory mode
    mstate = 2'b01; boot_addr = 24'hABC123;
    wd_en = 1'b1; wd_timeout = 29'h1234567;
    cur_view = 1'b0; read(2'd0, "R7");
    cur_view = 1'b1; read(2'd0, "R7");
    read(2'd1, "R10");
    read(2'd2, "R10");
    fire(5'b00100, 24'h111111, 2'b10);   // R6: ignored in factory
    read(2'd3, "R11");

    // enter application mode
    app_mode = 1'b1;
    tick("R10");
    read(2'd1, "R6");
    read(2'd2, "R6");
    cur_view = 1'b1; wd_en = 1'b0; wd_timeout = 29'h1FFFFFFF; mstate = 2'b11;
    read(2'd0, "R8");
    wd_en = 1'b1; wd_timeout = 29'h0000ABC;
    read(2'd0, "R8");
    cur_view = 1'b0; boot_addr = 24'h5A5A5A;
    read(2'd0, "R9");

    // single triggers (R2, R3, R4)
    for (int k = 0; k < 5; k++) begin
      fire(5'b1 << k, 24'h100000 + 24'(k * 24'h010203), 2'(k));
      read(2'd1, "R3");
      read(2'd2, "R4");
    end

    // simultaneous triggers
    fire(5'b10101, 24'hFEDCBA, 2'b11);  read(2'd1, "R2");
    fire(5'b01110, 24'h000001, 2'b00);  read(2'd1, "R2");
    fire(5'b00011, 24'h800000, 2'b01);  read(2'd1, "R2"); read(2'd2, "R4");

    // held trigger, second line raised while held (R5)
    boot_addr = 24'h0C0C0C; mstate = 2'b10;
    trig_i = 5'b00001; tick("R5"); tick("R5");
    boot_addr = 24'h0D0D0D;
    trig_i = 5'b10001; tick("R5"); tick("R5");
    read(2'd1, "R5");
    read(2'd2, "R5");
    trig_i = '0; tick("R5");
    read(2'd1, "R5");

    // factory again with trigger: no shift (R6)
    app_mode = 1'b0;
    fire(5'b01000, 24'h777777, 2'b11);
    read(2'd1, "R6");
    read(2'd2, "R6");

    // R11: select 3 and data hold
    read(2'd3, "R11");
    read(2'd0, "R11");
    @(negedge clk);
    held = rd_data;
    boot_addr = ~boot_addr;
    repeat (3) tick("R11");
    check("R11", rd_data, held);
    check("R11", {31'b0, rd_valid}, 32'h0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule